// File: doc/BRIEF.md
# Prioritised Interrupt Mask Unit

This unit is the interrupt front end of a small 8-bit processor core. It watches five request lines of mixed trigger types, qualifies them with a mask register and a global enable flag, and resolves them to one pending request. For that request it presents the service vector address. The lowest-priority line has no fixed vector, so for it the unit raises an acknowledge request instead. The core accepts the presented request with a one-cycle accept strobe.

Software controls the unit through two accumulator-style operations. A set-mask write updates the three maskable-line masks, but only when its mask-enable bit is set. The same write can clear the edge latch of the highest maskable line and drive a serial output bit. A read-mask word is always available on an output port. It returns the masks, the global enable, the pending request lines and the serial input. Separate enable and disable commands set and clear the global enable.

Top module: `irq_prio_unit`

## Requirements
- R1: When several qualified requests are present, exactly one wins, in the order TRAP (highest), then the RST7.5 line, RST6.5, RST5.5 and INTR (lowest).
- R2: The winner's vector on irq_vec_o is 16'h0024 for TRAP, 16'h003C for RST7.5, 16'h0034 for RST6.5 and 16'h002C for RST5.5, that is, the restart number times 8.
- R3: TRAP ignores the masks and the global enable. It is requested only once a rising edge has been sampled and while the line stays high. Its request drops as soon as the line goes low. After it is accepted, it stays idle until the line has gone low and risen again.
- R4: The RST7.5 line is edge-triggered. A sampled rising edge sets a latch that stays set after the line falls. A line held high with no new edge does not set the latch again.
- R5: RST6.5, RST5.5 and INTR are level-triggered. Each requests only while its line is high.
- R6: A set-mask write loads data bits 2, 1 and 0 as the masks for RST7.5, RST6.5 and RST5.5 (1 = masked), but only when data bit 3 is 1. With bit 3 at 0 the masks are unchanged. After reset all three are masked.
- R7: A set-mask write with data bit 4 set clears the RST7.5 latch.
- R8: A set-mask write with data bit 6 set copies data bit 7 to sout_o. With bit 6 clear, sout_o holds its value. sout_o is 0 after reset.
- R9: mask_word_o carries the serial input in bit 7, the pending RST7.5 latch in bit 6, the raw RST6.5 and RST5.5 lines in bits 5 and 4, the global enable in bit 3, and the RST7.5, RST6.5 and RST5.5 masks in bits 2 to 0. Pending bits show requests before masking.
- R10: The global enable is 0 after reset. It is set by en_cmd_i and cleared by dis_cmd_i, and it is also cleared when any maskable request is accepted. While it is 0, only TRAP can be presented.
- R11: When INTR wins, intr_ack_req_o is 1 and irq_vec_o is 16'h0000.
- R12: Accepting an RST7.5 request clears its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable request line |
| rst75_i | input | 1 | Edge-triggered maskable request line |
| rst65_i | input | 1 | Level-triggered maskable request line |
| rst55_i | input | 1 | Level-triggered maskable request line |
| intr_i | input | 1 | Level-triggered request line with externally supplied vector |
| set_mask_we_i | input | 1 | Set-mask write strobe |
| set_mask_data_i | input | 8 | Set-mask write data |
| en_cmd_i | input | 1 | Set the global enable |
| dis_cmd_i | input | 1 | Clear the global enable |
| accept_i | input | 1 | Core accepts the presented request |
| sin_i | input | 1 | Serial input bit |
| mask_word_o | output | 8 | Read-mask word |
| sout_o | output | 1 | Serial output bit |
| irq_valid_o | output | 1 | A request is presented |
| irq_vec_o | output | 16 | Vector of the presented request |
| intr_ack_req_o | output | 1 | INTR won; an acknowledge cycle is needed |

## Verification
The resolver is first driven from a table that combines the three level lines, the masks and the global enable. This separates a priority fault from a mask-bit mapping fault and from a missing enable gate. Directed sequences then isolate the edge behaviour. A one-cycle pulse on the RST7.5 line shows that it is latched, a held-high line shows that it is not re-latched, and the TRAP line is raised, accepted, held, dropped and raised again to show the edge-plus-level rule. Set-mask writes with bit 3, 4 or 6 cleared, and the read-mask word sampled after accepts, show which side effects each control bit and each accept carries.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC   = 5;
  localparam int unsigned NUM_VEC   = 4;
  localparam int unsigned MASK_W    = 3;
  localparam int unsigned CTRL_W    = 8;

  // source index order is priority order
  localparam int unsigned IDX_TRAP = 0;
  localparam int unsigned IDX_R75  = 1;
  localparam int unsigned IDX_R65  = 2;
  localparam int unsigned IDX_R55  = 3;
  localparam int unsigned IDX_INTR = 4;

  // restart numbers doubled (TRAP=4.5 -> 9), vector = half_rst * 4
  function automatic int unsigned half_restart(input int unsigned idx);
    case (idx)
      IDX_TRAP: half_restart = 9;
      IDX_R75:  half_restart = 15;
      IDX_R65:  half_restart = 13;
      default:  half_restart = 11;
    endcase
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         valid_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | req_i[i];
  end

  assign valid_o = taken[N];
endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trap_i,
  input  logic r75_i,
  input  logic clr75_i,
  input  logic ack75_i,
  input  logic acktrap_i,
  output logic trap_req_o,
  output logic lat75_o
);
  logic trap_q, trap_lat, r75_q, lat75;
  logic trap_rise, r75_rise;

  assign trap_rise = trap_i & ~trap_q;
  assign r75_rise  = r75_i & ~r75_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q   <= 1'b0;
      r75_q    <= 1'b0;
      trap_lat <= 1'b0;
      lat75    <= 1'b0;
    end else begin
      trap_q <= trap_i;
      r75_q  <= r75_i;
      if (trap_rise)                  trap_lat <= 1'b1;
      else if (!trap_i || acktrap_i)  trap_lat <= 1'b0;
      // a new edge outranks a clear in the same cycle
      if (r75_rise)                   lat75 <= 1'b1;
      else if (clr75_i || ack75_i)    lat75 <= 1'b0;
    end
  end

  assign trap_req_o = trap_lat & trap_i;
  assign lat75_o    = lat75;

  assert_trap_rearm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acktrap_i && trap_i) |=> !trap_req_o);

  assert_l75_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr75_i && !r75_rise) |=> !lat75_o);

  assert_l75_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat75_o && !clr75_i && !ack75_i) |=> lat75_o);
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] wmask_i,
  input  logic              mse_i,
  input  logic              sde_i,
  input  logic              sod_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              take_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              ie_o,
  output logic              sout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      ie_o   <= 1'b0;
      sout_o <= 1'b0;
    end else begin
      if (wr_i && mse_i) mask_o <= wmask_i;
      if (wr_i && sde_i) sout_o <= sod_i;
      if (dis_i || take_i) ie_o <= 1'b0;
      else if (en_i)       ie_o <= 1'b1;
    end
  end

  assert_mse_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mse_i) |=> $stable(mask_o));

  assert_ie_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i || take_i) |=> !ie_o);

  assert_sod_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sde_i) |=> $stable(sout_o));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic              rst75_i,
  input  logic              rst65_i,
  input  logic              rst55_i,
  input  logic              intr_i,
  input  logic              set_mask_we_i,
  input  logic [CTRL_W-1:0] set_mask_data_i,
  input  logic              en_cmd_i,
  input  logic              dis_cmd_i,
  input  logic              accept_i,
  input  logic              sin_i,
  output logic [CTRL_W-1:0] mask_word_o,
  output logic              sout_o,
  output logic              irq_valid_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              intr_ack_req_o
);
  logic [MASK_W-1:0]  mask;
  logic               ie, trap_req, lat75;
  logic [NUM_SRC-1:0] req, grant;
  logic               take_mask, ack75, acktrap, clr75;
  logic [VEC_W-1:0]   vec_tab [NUM_VEC];
  logic               unused_bit5;

  assign unused_bit5 = set_mask_data_i[5];
  assign clr75       = set_mask_we_i & set_mask_data_i[4];

  irq_edge_cap u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trap_i    (trap_i),
    .r75_i     (rst75_i),
    .clr75_i   (clr75),
    .ack75_i   (ack75),
    .acktrap_i (acktrap),
    .trap_req_o(trap_req),
    .lat75_o   (lat75)
  );

  irq_mask_ctl u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (set_mask_we_i),
    .wmask_i(set_mask_data_i[MASK_W-1:0]),
    .mse_i  (set_mask_data_i[3]),
    .sde_i  (set_mask_data_i[6]),
    .sod_i  (set_mask_data_i[7]),
    .en_i   (en_cmd_i),
    .dis_i  (dis_cmd_i),
    .take_i (take_mask),
    .mask_o (mask),
    .ie_o   (ie),
    .sout_o (sout_o)
  );

  assign req[IDX_TRAP] = trap_req;
  assign req[IDX_R75]  = lat75   & ~mask[2] & ie;
  assign req[IDX_R65]  = rst65_i & ~mask[1] & ie;
  assign req[IDX_R55]  = rst55_i & ~mask[0] & ie;
  assign req[IDX_INTR] = intr_i  & ie;

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .req_i  (req),
    .grant_o(grant),
    .valid_o(irq_valid_o)
  );

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    assign vec_tab[i] = VEC_W'(half_restart(i) * 4);
  end

  always_comb begin
    irq_vec_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i]) irq_vec_o = vec_tab[i];
    end
  end

  assign intr_ack_req_o = grant[IDX_INTR];
  assign acktrap        = accept_i & grant[IDX_TRAP];
  assign ack75          = accept_i & grant[IDX_R75];
  assign take_mask      = accept_i & irq_valid_o & ~grant[IDX_TRAP];

  assign mask_word_o = {sin_i, lat75, rst65_i, rst55_i, ie, mask};

  assert_trap_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req |-> (irq_valid_o && irq_vec_o == VEC_W'(16'h0024)));

  assert_gate_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && !ie) |-> trap_req);

  assert_intr_novec_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_ack_req_o |-> (irq_vec_o == '0 && !trap_req));

  assert_take75_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && grant[IDX_R75]) |=> !(irq_valid_o && irq_vec_o == VEC_W'(16'h003C)));

  assert_one_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> $countones(grant) == 1);
endmodule

// File: tb/test_irq_prio_unit.sv
`timescale 1ns/1ps
module test_irq_prio_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap = 0, r75 = 0, r65 = 0, r55 = 0, intr = 0;
  logic we = 0;
  logic [7:0] wdat = '0;
  logic en = 0, dis = 0, acc = 0, sin = 0;
  logic [7:0] mword;
  logic sout, valid, ackreq;
  logic [15:0] vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_unit i_irq_prio_unit (
    .clk_i(clk), .rst_ni(rst_n), .trap_i(trap), .rst75_i(r75), .rst65_i(r65),
    .rst55_i(r55), .intr_i(intr), .set_mask_we_i(we), .set_mask_data_i(wdat),
    .en_cmd_i(en), .dis_cmd_i(dis), .accept_i(acc), .sin_i(sin),
    .mask_word_o(mword), .sout_o(sout), .irq_valid_o(valid), .irq_vec_o(vec),
    .intr_ack_req_o(ackreq)
  );

  // {mask[2:0], lines{r65,r55,intr}, ie, exp_valid, exp_ack, exp_vec[7:0]}
  localparam logic [16:0] TBL [8] = '{
    {3'b000, 3'b111, 1'b1, 1'b1, 1'b0, 8'h34},
    {3'b010, 3'b111, 1'b1, 1'b1, 1'b0, 8'h2C},
    {3'b011, 3'b111, 1'b1, 1'b1, 1'b1, 8'h00},
    {3'b000, 3'b111, 1'b0, 1'b0, 1'b0, 8'h00},
    {3'b000, 3'b001, 1'b1, 1'b1, 1'b1, 8'h00},
    {3'b000, 3'b010, 1'b1, 1'b1, 1'b0, 8'h2C},
    {3'b001, 3'b010, 1'b1, 1'b0, 1'b0, 8'h00},
    {3'b100, 3'b100, 1'b1, 1'b1, 1'b0, 8'h34}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mask(input logic [7:0] d);
    we = 1; wdat = d; tick(); we = 0; wdat = '0; #1;
  endtask

  task automatic pulse_en();
    en = 1; tick(); en = 0; #1;
  endtask

  task automatic pulse_dis();
    dis = 1; tick(); dis = 0; #1;
  endtask

  task automatic pulse_acc();
    acc = 1; tick(); acc = 0; #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // reset state
    chk("R6 R9 R10 reset word", {8'h0, mword}, 16'h0007);
    chk("R10 reset valid", {15'h0, valid}, 16'h0);
    chk("R8 reset sout", {15'h0, sout}, 16'h0);

    // table walk over level lines, masks and enable
    for (int k = 0; k < 8; k++) begin
      logic [16:0] e;
      e = TBL[k];
      set_mask({5'b00001, e[16:14]});
      if (e[10]) pulse_en(); else pulse_dis();
      {r65, r55, intr} = e[13:11];
      #1;
      chk("R1 R2 R5 R6 R10 valid", {15'h0, valid}, {15'h0, e[9]});
      chk("R2 R11 vec", vec, {8'h0, e[7:0]});
      chk("R11 ack", {15'h0, ackreq}, {15'h0, e[8]});
      chk("R9 word", {10'h0, mword[5:0]}, {10'h0, e[13:12], e[10], e[16:14]});
    end
    {r65, r55, intr} = 3'b000;
    #1;
    chk("R5 lines low", {15'h0, valid}, 16'h0);

    // MSE gate
    set_mask(8'h08);
    set_mask(8'h07);
    chk("R6 mse=0 keeps masks", {13'h0, mword[2:0]}, 16'h0);

    // 7.5 latch, priority over 6.5, accept clears latch and enable
    pulse_en();
    r65 = 1;
    r75 = 1; tick(); r75 = 0; #1;
    chk("R4 latched after pulse", {15'h0, mword[6]}, 16'h1);
    chk("R1 R2 7.5 beats 6.5", vec, 16'h003C);
    pulse_acc();
    chk("R12 latch cleared by accept", {15'h0, mword[6]}, 16'h0);
    chk("R10 accept clears enable", {15'h0, mword[3]}, 16'h0);
    chk("R10 nothing presented", {15'h0, valid}, 16'h0);
    r65 = 0;

    // latch reset bit, pending shown while masked
    pulse_en();
    set_mask(8'h0C);
    r75 = 1; tick(); r75 = 0; #1;
    chk("R9 pending while masked", {15'h0, mword[6]}, 16'h1);
    chk("R6 masked 7.5 not presented", {15'h0, valid}, 16'h0);
    set_mask(8'h1C);
    chk("R7 latch reset bit", {15'h0, mword[6]}, 16'h0);

    // held level with no new edge
    set_mask(8'h08);
    r75 = 1; tick(); #1;
    chk("R4 edge while enabled", vec, 16'h003C);
    set_mask(8'h18);
    tick();
    chk("R4 held level no relatch", {15'h0, mword[6]}, 16'h0);
    chk("R4 held level no request", {15'h0, valid}, 16'h0);
    r75 = 0;

    // TRAP with enable off and all masked
    pulse_dis();
    set_mask(8'h0F);
    trap = 1; #1;
    chk("R3 no edge sampled yet", {15'h0, valid}, 16'h0);
    tick();
    chk("R3 trap vector", vec, 16'h0024);
    pulse_acc();
    chk("R3 held after accept", {15'h0, valid}, 16'h0);
    trap = 0; tick();
    trap = 1; tick();
    chk("R3 re-armed", {15'h0, valid}, 16'h1);
    trap = 0; #1;
    chk("R3 drops with level", {15'h0, valid}, 16'h0);

    // serial path
    set_mask(8'hC0);
    chk("R8 sod loaded", {15'h0, sout}, 16'h1);
    set_mask(8'h80);
    chk("R8 sde clear holds", {15'h0, sout}, 16'h1);
    set_mask(8'h40);
    chk("R8 sod cleared", {15'h0, sout}, 16'h0);
    sin = 1; #1;
    chk("R9 serial in bit", {15'h0, mword[7]}, 16'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule